// File: doc/BRIEF.md
# Set/Clear Control Register Bank with Masked Interrupt

This block is a register slice that a peripheral places on a 32-bit, word-only register bus. Software changes single bits without read-modify-write. One address sets bits, another clears them, and a third reads the result. The same scheme holds the interrupt mask. A write-only command register turns each one written into a one-cycle pulse. A plain mode register holds configuration.

The peripheral supplies its raw event levels on `evt_i`. Each event is ANDed with its mask bit, and the results are ORed into `irq_o`. The peripheral reads the control bits on `ctrl_o`. It can also drop any of them through `ctrl_clr_i`, and that clear beats a bus set of the same bit in the same cycle.

Only the low `NB` bits of each register exist (default 16). The other bits read as zero and ignore writes. The two lowest address bits are ignored, so every access acts on a whole word.

Register byte offsets (decoded from `bus_addr[5:2]`): 0x00 command (write-only), 0x04 mode, 0x08 control set, 0x0C control clear, 0x10 control read, 0x14 raw events read, 0x18 mask set, 0x1C mask clear, 0x20 mask read. Any other offset reads zero and ignores writes.

Top module: `scbank_top`

## Requirements
- R1: A write to offset 0x08 sets every `ctrl_o` bit where the write data holds a one, at the clock edge of the write. Bits written zero keep their value.
- R2: A write to offset 0x0C clears every `ctrl_o` bit where the write data holds a one, at the clock edge of the write. Bits written zero keep their value. Offset 0x10 reads `ctrl_o`.
- R3: The mask reads at offset 0x20. It is set by ones written to offset 0x18 and cleared by ones written to offset 0x1C. It changes in no other way.
- R4: `irq_o` is high exactly when some bit is high in both `evt_i` and the mask. It follows `evt_i` in the same cycle and follows a mask write after that write's clock edge.
- R5: `bus_addr[1:0]` is ignored. Any access with the same `bus_addr[5:2]` reaches the same register.
- R6: Bits 31 down to `NB` of `bus_rdata` are always zero, and write data in those bits has no effect. Unmapped offsets read zero. Writes to unmapped offsets, or to the read-only offsets 0x10, 0x14 and 0x20, change nothing.
- R7: After reset, the control bits, the mask, the mode register and `cmd_o` are all zero.
- R8: A write to offset 0x00 drives `cmd_o` to the low `NB` bits of the data for exactly the one cycle after the write edge. Offset 0x00 reads zero.
- R9: A one on `ctrl_clr_i` clears that control bit at the next edge. If a bus set of the same bit happens in that cycle, the clear wins.
- R10: Offset 0x14 reads the current `evt_i` value. Offset 0x04 reads back the mode value last written, and `mode_o` shows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Byte address. Bits 1:0 are ignored |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_i | input | NB | Raw event levels from the peripheral |
| ctrl_clr_i | input | NB | Peripheral-side clear of control bits |
| ctrl_o | output | NB | Control bits |
| mode_o | output | NB | Mode register |
| cmd_o | output | NB | One-cycle command pulses |
| irq_o | output | 1 | Masked, ORed interrupt request |

## Verification
Each register sits behind the read port, so a wrong control or mask bit shows in `bus_rdata` on the first read after the faulty edge. A wrong mask bit also shows in `irq_o` as soon as a matching event level is applied. A command pulse that is lost or stretched shows on `cmd_o` one cycle after the write. A clear that loses to a set shows in the control read at the next cycle.

// File: rtl/scbank_pkg.sv
package scbank_pkg;
  localparam int DW = 32;
  localparam int AW = 6;

  typedef enum logic [3:0] {
    RG_CMD  = 4'd0,
    RG_MODE = 4'd1,
    RG_CSET = 4'd2,
    RG_CCLR = 4'd3,
    RG_CRD  = 4'd4,
    RG_EVT  = 4'd5,
    RG_MSET = 4'd6,
    RG_MCLR = 4'd7,
    RG_MRD  = 4'd8
  } reg_e;

  // word index: byte lanes dropped
  function automatic logic [3:0] word_idx(input logic [AW-1:0] a);
    return a[AW-1:2];
  endfunction

  // next value of a set/clear bit vector; clear has priority
  function automatic logic [DW-1:0] sc_next(input logic [DW-1:0] q,
                                            input logic [DW-1:0] s,
                                            input logic [DW-1:0] c);
    return (q | s) & ~c;
  endfunction
endpackage

// File: rtl/scbank_screg.sv
module scbank_screg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  import scbank_pkg::*;

  logic [DW-1:0] nxt;

  always_comb begin
    nxt = sc_next(DW'(q_o), DW'(set_i), DW'(clr_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= nxt[W-1:0];
  end
endmodule

// File: rtl/scbank_pulse.sv
module scbank_pulse #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] pulse_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pulse_o <= '0;
    else if (fire_i) pulse_o <= bits_i;
    else             pulse_o <= '0;
  end
endmodule

// File: rtl/scbank_irq.sv
module scbank_irq #(
  parameter int W = 16
) (
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  logic [W-1:0] gated;

  for (genvar i = 0; i < W; i++) begin : g_gate
    assign gated[i] = evt_i[i] & mask_i[i];
  end

  assign irq_o = |gated;
endmodule

// File: rtl/scbank_top.sv
module scbank_top #(
  parameter int NB = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [5:0]    bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [NB-1:0] evt_i,
  input  logic [NB-1:0] ctrl_clr_i,
  output logic [NB-1:0] ctrl_o,
  output logic [NB-1:0] mode_o,
  output logic [NB-1:0] cmd_o,
  output logic          irq_o
);
  import scbank_pkg::*;

  localparam int PAD = DW - NB;

  logic [3:0]    widx;
  logic [NB-1:0] wbits;
  logic          wr_cmd, wr_mode, wr_cset, wr_cclr, wr_mset, wr_mclr;
  logic [NB-1:0] ctrl_set, ctrl_clr, mask_set, mask_clr;
  logic [NB-1:0] mask_q;

  assign widx  = word_idx(bus_addr);
  assign wbits = bus_wdata[NB-1:0];

  assign wr_cmd  = bus_we && (widx == RG_CMD);
  assign wr_mode = bus_we && (widx == RG_MODE);
  assign wr_cset = bus_we && (widx == RG_CSET);
  assign wr_cclr = bus_we && (widx == RG_CCLR);
  assign wr_mset = bus_we && (widx == RG_MSET);
  assign wr_mclr = bus_we && (widx == RG_MCLR);

  assign ctrl_set = wr_cset ? wbits : '0;
  assign ctrl_clr = (wr_cclr ? wbits : '0) | ctrl_clr_i;
  assign mask_set = wr_mset ? wbits : '0;
  assign mask_clr = wr_mclr ? wbits : '0;

  scbank_screg #(.W(NB)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .set_i(ctrl_set), .clr_i(ctrl_clr), .q_o(ctrl_o)
  );

  scbank_screg #(.W(NB)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_i(mask_set), .clr_i(mask_clr), .q_o(mask_q)
  );

  scbank_pulse #(.W(NB)) u_cmd (
    .clk(clk), .rst_n(rst_n), .fire_i(wr_cmd), .bits_i(wbits), .pulse_o(cmd_o)
  );

  scbank_irq #(.W(NB)) u_irq (
    .evt_i(evt_i), .mask_i(mask_q), .irq_o(irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_o <= '0;
    else if (wr_mode) mode_o <= wbits;
  end

  logic [NB-1:0] rd_bits;

  always_comb begin
    unique case (widx)
      RG_MODE: rd_bits = mode_o;
      RG_CRD:  rd_bits = ctrl_o;
      RG_EVT:  rd_bits = evt_i;
      RG_MRD:  rd_bits = mask_q;
      default: rd_bits = '0;
    endcase
  end

  assign bus_rdata = {{PAD{1'b0}}, rd_bits};
endmodule

// File: rtl/scbank_chk.sv
module scbank_chk #(
  parameter int NB = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic [NB-1:0] evt_i,
  input logic [NB-1:0] ctrl_clr_i,
  input logic [NB-1:0] ctrl_o,
  input logic [NB-1:0] cmd_o,
  input logic [NB-1:0] mask_q,
  input logic          irq_o,
  input logic          wr_cmd,
  input logic          wr_cset,
  input logic          wr_cclr,
  input logic          wr_mset,
  input logic          wr_mclr
);
  // R1
  ctrl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cset |=> ((ctrl_o & $past(bus_wdata[NB-1:0] & ~ctrl_clr_i)) ==
                 $past(bus_wdata[NB-1:0] & ~ctrl_clr_i)));
  // R2
  ctrl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cclr |=> ((ctrl_o & $past(bus_wdata[NB-1:0])) == '0));
  // R3
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_mset || wr_mclr) |=> $stable(mask_q));
  // R4
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i == '0) |-> !irq_o);
  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:NB] == '0);
  // R8
  cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cmd |=> (cmd_o == '0));
  // R9
  hw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_clr_i != '0) |=> ((ctrl_o & $past(ctrl_clr_i)) == '0));
endmodule

bind scbank_top scbank_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .evt_i(evt_i), .ctrl_clr_i(ctrl_clr_i), .ctrl_o(ctrl_o), .cmd_o(cmd_o),
  .mask_q(mask_q), .irq_o(irq_o), .wr_cmd(wr_cmd), .wr_cset(wr_cset),
  .wr_cclr(wr_cclr), .wr_mset(wr_mset), .wr_mclr(wr_mclr)
);

// File: tb/scbank_top_bench.sv
`timescale 1ns/1ps
module scbank_top_bench;
  localparam int NB = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NB-1:0] evt_i = '0;
  logic [NB-1:0] ctrl_clr_i = '0;
  logic [NB-1:0] ctrl_o, mode_o, cmd_o;
  logic          irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  scbank_top #(.NB(NB)) u_scbank_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
    .ctrl_clr_i(ctrl_clr_i), .ctrl_o(ctrl_o), .mode_o(mode_o),
    .cmd_o(cmd_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [5:0]  wa;
    logic [31:0] wd;
    logic [5:0]  ra;
    logic [31:0] exp;
    logic        irq;
  } vec_t;

  // evt_i is held at 0x00F0 while the table runs
  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{6'h08, 32'h0000_000F, 6'h10, 32'h0000_000F, 1'b0}, // R1
    '{6'h08, 32'hFFFF_0030, 6'h10, 32'h0000_003F, 1'b0}, // R1 R6
    '{6'h0C, 32'h0000_0005, 6'h10, 32'h0000_003A, 1'b0}, // R2
    '{6'h0C, 32'h0000_0000, 6'h10, 32'h0000_003A, 1'b0}, // R2
    '{6'h18, 32'h0000_0180, 6'h20, 32'h0000_0180, 1'b1}, // R3 R4
    '{6'h1C, 32'h0000_0080, 6'h20, 32'h0000_0100, 1'b0}, // R3 R4
    '{6'h04, 32'hABCD_1234, 6'h04, 32'h0000_1234, 1'b0}, // R10 R6
    '{6'h09, 32'h0000_0040, 6'h10, 32'h0000_007A, 1'b0}, // R5
    '{6'h1B, 32'h0000_0010, 6'h22, 32'h0000_0110, 1'b1}, // R5 R4
    '{6'h00, 32'h0000_0005, 6'h00, 32'h0000_0000, 1'b1}, // R8
    '{6'h10, 32'h0000_FFFF, 6'h10, 32'h0000_007A, 1'b1}, // R6
    '{6'h3C, 32'h0000_FFFF, 6'h14, 32'h0000_00F0, 1'b1}, // R10 R6
    '{6'h1C, 32'h0000_0000, 6'h20, 32'h0000_0110, 1'b1}  // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [5:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    rd("R7 ctrl", 6'h10, 32'h0);
    rd("R7 mask", 6'h20, 32'h0);
    rd("R7 mode", 6'h04, 32'h0);
    chk("R7 cmd", 32'(cmd_o), 32'h0);
    chk("R7 irq", 32'(irq_o), 32'h0);

    evt_i = 16'h00F0;
    for (int i = 0; i < NV; i++) begin
      bus_write(VEC[i].wa, VEC[i].wd);
      rd($sformatf("vec%0d R1-table", i), VEC[i].ra, VEC[i].exp);
      chk($sformatf("vec%0d R4 irq", i), 32'(irq_o), 32'(VEC[i].irq));
    end

    // R8 command pulse lasts one cycle
    @(negedge clk);
    bus_addr = 6'h00; bus_wdata = 32'hFFFF_8001; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    #1 chk("R8 pulse", 32'(cmd_o), 32'h0000_8001);
    @(negedge clk);
    #1 chk("R8 end", 32'(cmd_o), 32'h0);

    // R9 hardware clear wins against a bus set in the same cycle
    @(negedge clk);
    bus_addr = 6'h08; bus_wdata = 32'h0000_0101; bus_we = 1'b1;
    ctrl_clr_i = 16'h0001;
    @(negedge clk);
    bus_we = 1'b0; ctrl_clr_i = '0;
    rd("R9 clear wins", 6'h10, 32'h0000_017A);
    chk("R9 ctrl_o", 32'(ctrl_o), 32'h0000_017A);

    // R9 hardware clear alone
    @(negedge clk);
    ctrl_clr_i = 16'h0030;
    @(negedge clk);
    ctrl_clr_i = '0;
    rd("R9 hw clear", 6'h10, 32'h0000_014A);

    // R4 irq follows events combinationally
    evt_i = 16'h0000;
    #1 chk("R4 no event", 32'(irq_o), 32'h0);
    evt_i = 16'h0100;
    #1 chk("R4 masked event", 32'(irq_o), 32'h1);
    evt_i = 16'h8000;
    #1 chk("R4 unmasked event", 32'(irq_o), 32'h0);
    rd("R10 events", 6'h17, 32'h0000_8000);
    chk("R10 mode_o", 32'(mode_o), 32'h0000_1234);

    // R7 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    rd("R7 ctrl again", 6'h10, 32'h0);
    rd("R7 mask again", 6'h20, 32'h0);
    rd("R7 mode again", 6'h04, 32'h0);
    evt_i = 16'hFFFF;
    #1 chk("R7 irq again", 32'(irq_o), 32'h0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule